// File: doc/BRIEF.md
# Interrupt Cause and Mask Register Block

This block sits between a processor and its peripherals and turns a set of peripheral interrupt requests into one external interrupt line. Each peripheral gets a sticky bit in a 32-bit cause register. Its request inputs set or clear that bit. Software clears bits by writing ones. A mask register picks which latched causes may drive the interrupt line. One cause bit follows a reset push-button. It reads 1 while the button is released.

The same register window holds several other registers:
- three address registers for a write-gathering FIFO, always kept aligned to 32 bytes;
- a constant revision word;
- a reset-code register that reads back what was written.

Writing the reset-code register with bit 2 clear, while the legacy-mode input is high, gives a one-cycle reset pulse toward the disc drive. The bus is a single-cycle synchronous port. Reads are combinational and can fetch either 16-bit half of any register.

Top module: `sysif_irq_regs`

## Requirements
- R1: `irq_out` is high exactly when the bitwise AND of the cause and mask registers is nonzero. It follows any register change in the same cycle the register updates.
- R2: A 32-bit write to the cause register clears every cause bit whose written value is 1. Bits written 0 keep their value.
- R3: A 32-bit write to the mask register replaces all 32 of its bits.
- R4: A pulse on `src_set[i]` sets cause bit i, and a pulse on `src_clr[i]` clears it (i from 0 to 14). If a set coincides with a clear request or a software clear of the same bit, the set wins.
- R5: Cause bit 16 tracks the inverse of `btn_pressed`:
  - it is cleared on the press edge;
  - it is set on the release edge;
  - between edges, software may clear it by writing a 1.
- R6: After reset, the cause register reads 0x00010100 (bits 16 and 8), and the mask, the FIFO registers and the reset code read 0. `irq_out` and `drv_rst_pulse` are low.
- R7: The FIFO base, end and write-pointer registers store the written word with bits 4:0 forced to 0.
- R8: The revision register always reads 0x246500B1, and writes to it have no effect.
- R9: The reset-code register reads back the last 32-bit value written. A write with bit 2 clear while `legacy_mode` is 1 raises `drv_rst_pulse` for exactly the following cycle. No other write raises it.
- R10: With `bus_half` set, a read at byte offset +0 of a register returns bits 31:16 zero-extended, and a read at +2 returns bits 15:0.
- R11: Writes with `bus_half` set change no register and raise no pulse.
- R12: The register map, by byte offset, is:
  - cause 0x00, mask 0x04;
  - FIFO base 0x0C, FIFO end 0x10, FIFO write pointer 0x14;
  - FIFO reset 0x18, which is write-only, reads 0 and has no effect;
  - reset code 0x24;
  - revision 0x2C.

  Unmapped offsets and odd byte addresses read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_half | input | 1 | 1 = 16-bit access, 0 = 32-bit access |
| bus_addr | input | ADDR_W | Byte address within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not reading |
| src_set | input | NUM_SRC | Per-source set request pulses, cause bits 0..14 |
| src_clr | input | NUM_SRC | Per-source clear request pulses, cause bits 0..14 |
| btn_pressed | input | 1 | Reset push-button level, 1 = pressed |
| legacy_mode | input | 1 | Enables the drive-reset pulse |
| irq_out | output | 1 | External interrupt to the processor |
| drv_rst_pulse | output | 1 | One-cycle drive reset request |

## Verification
The bench looks for collisions inside a single cycle:
- A set request that meets a clear request or a software clear must leave the bit set. A design with the wrong priority would drop an interrupt.
- Writes of zero to the cause register must change nothing. A design that stored the value instead of clearing by ones would wipe every pending cause.

The FIFO registers are written with low-order ones. Keeping those bits would leave a misaligned pointer.

Halfword reads are checked at both offsets. Swapped halves would show at once on the revision word.

The drive pulse is checked against each blocking condition in turn: legacy mode off, bit 2 set, and a 16-bit write. A loose decode would reset the drive on a harmless write.

The button bit is checked across a press, a release and a software clear. An edge detector with the wrong polarity would leave the interrupt asserted while the button is held down.

// File: rtl/sysif_pkg.sv
package sysif_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned HALF_W     = WORD_W / 2;
    localparam int unsigned NUM_SRC    = 15;
    localparam int unsigned BTN_BIT    = 16;
    localparam int unsigned VIDEO_BIT  = 8;
    localparam int unsigned ALIGN_BITS = 5;
    localparam int unsigned KEEP_BIT   = 2;
    localparam logic [WORD_W-1:0] REV_WORD = 32'h2465_00B1;

    // word indices (byte offset / 4)
    localparam int unsigned IDX_CAUSE = 0;
    localparam int unsigned IDX_MASK  = 1;
    localparam int unsigned IDX_FBASE = 3;
    localparam int unsigned IDX_FEND  = 4;
    localparam int unsigned IDX_FWPTR = 5;
    localparam int unsigned IDX_FRST  = 6;
    localparam int unsigned IDX_RCODE = 9;
    localparam int unsigned IDX_REV   = 11;

    localparam int unsigned NUM_FIFO_REGS = 3;

    typedef enum logic [3:0] {
        SEL_NONE, SEL_CAUSE, SEL_MASK, SEL_FBASE, SEL_FEND,
        SEL_FWPTR, SEL_FRST, SEL_RCODE, SEL_REV
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e sel;
        logic     wr_word;
        logic     rd_any;
        logic     rd_half;
        logic     lo_half;
    } bus_dec_t;

    function automatic reg_sel_e decode_index(input int unsigned idx);
        case (idx)
            IDX_CAUSE: return SEL_CAUSE;
            IDX_MASK:  return SEL_MASK;
            IDX_FBASE: return SEL_FBASE;
            IDX_FEND:  return SEL_FEND;
            IDX_FWPTR: return SEL_FWPTR;
            IDX_FRST:  return SEL_FRST;
            IDX_RCODE: return SEL_RCODE;
            IDX_REV:   return SEL_REV;
            default:   return SEL_NONE;
        endcase
    endfunction

    function automatic reg_sel_e fifo_sel(input int unsigned n);
        case (n)
            0:       return SEL_FBASE;
            1:       return SEL_FEND;
            default: return SEL_FWPTR;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] half_pick(input logic [WORD_W-1:0] w,
                                                    input logic lo);
        return lo ? {{HALF_W{1'b0}}, w[HALF_W-1:0]}
                  : {{HALF_W{1'b0}}, w[WORD_W-1:HALF_W]};
    endfunction

    function automatic logic [WORD_W-1:0] cause_impl_mask(input int unsigned nsrc);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int i = 0; i < int'(nsrc); i++) m[i] = 1'b1;
        m[BTN_BIT] = 1'b1;
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] cause_reset_val();
        logic [WORD_W-1:0] v;
        v = '0;
        v[BTN_BIT]   = 1'b1;
        v[VIDEO_BIT] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/sysif_cause_reg.sv
module sysif_cause_reg
    import sysif_pkg::*;
#(
    parameter int unsigned NSRC = NUM_SRC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              w1c_en,
    input  logic [WORD_W-1:0] w1c_data,
    input  logic [NSRC-1:0]   src_set,
    input  logic [NSRC-1:0]   src_clr,
    input  logic              btn_pressed,
    output logic [WORD_W-1:0] cause_q
);
    localparam logic [WORD_W-1:0] IMPL = cause_impl_mask(NSRC);

    logic              btn_q;
    logic              press_edge, release_edge;
    logic [WORD_W-1:0] set_v, clr_v, w1c_v, cause_d;

    assign press_edge   = btn_pressed & ~btn_q;
    assign release_edge = ~btn_pressed & btn_q;

    always_comb begin
        set_v = '0;
        clr_v = '0;
        set_v[NSRC-1:0] = src_set;
        clr_v[NSRC-1:0] = src_clr;
        set_v[BTN_BIT]  = release_edge;
        clr_v[BTN_BIT]  = press_edge;
        w1c_v   = w1c_en ? w1c_data : '0;
        // a fresh set outranks any clear arriving in the same cycle
        cause_d = ((cause_q & ~w1c_v & ~clr_v) | set_v) & IMPL;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= cause_reset_val();
            btn_q   <= 1'b0;
        end else begin
            cause_q <= cause_d;
            btn_q   <= btn_pressed;
        end
    end

    // R2: bits written with one are gone next cycle unless set anew
    a_r2_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        w1c_en |=> ((cause_q & $past(w1c_data & ~set_v)) == '0));

    // R4: a set request always lands
    a_r4_set_lands: assert property (@(posedge clk) disable iff (rst)
        (|set_v) |=> ((cause_q & $past(set_v)) == $past(set_v)));

    // R5: press clears the button bit, release sets it
    a_r5_press_clears: assert property (@(posedge clk) disable iff (rst)
        $rose(btn_pressed) |=> !cause_q[BTN_BIT]);
    a_r5_release_sets: assert property (@(posedge clk) disable iff (rst)
        ($fell(btn_pressed) && btn_q) |=> cause_q[BTN_BIT]);

endmodule

// File: rtl/sysif_fifo_addr.sv
module sysif_fifo_addr
    import sysif_pkg::*;
#(
    parameter int unsigned ALIGN = ALIGN_BITS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] ptr_q
);
    localparam logic [WORD_W-1:0] KEEP_MASK = ~((WORD_W'(1) << ALIGN) - WORD_W'(1));

    always_ff @(posedge clk) begin
        if (rst)        ptr_q <= '0;
        else if (wr_en) ptr_q <= wdata & KEEP_MASK;
    end

    // R7: stored value is the written word with the low bits zeroed
    a_r7_aligned_load: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ptr_q == {$past(wdata[WORD_W-1:ALIGN]), {ALIGN{1'b0}}}));

endmodule

// File: rtl/sysif_reset_code.sv
module sysif_reset_code
    import sysif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wdata,
    input  logic              legacy_mode,
    output logic [WORD_W-1:0] code_q,
    output logic              drv_pulse
);
    always_ff @(posedge clk) begin
        if (rst) begin
            code_q    <= '0;
            drv_pulse <= 1'b0;
        end else begin
            if (wr_en) code_q <= wdata;
            drv_pulse <= wr_en & legacy_mode & ~wdata[KEEP_BIT];
        end
    end

    // R9: readback after a write
    a_r9_readback: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (code_q == $past(wdata)));

    // R9: a pulse only ever follows a qualifying write
    a_r9_pulse_cause: assert property (@(posedge clk) disable iff (rst)
        drv_pulse |-> $past(wr_en && legacy_mode && !wdata[KEEP_BIT]));

endmodule

// File: rtl/sysif_irq_regs.sv
module sysif_irq_regs
    import sysif_pkg::*;
#(
    parameter int unsigned       ADDR_W = 12,
    parameter int unsigned       NSRC   = NUM_SRC,
    parameter logic [WORD_W-1:0] REV_ID = REV_WORD
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_half,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic [NSRC-1:0]   src_set,
    input  logic [NSRC-1:0]   src_clr,
    input  logic              btn_pressed,
    input  logic              legacy_mode,
    output logic              irq_out,
    output logic              drv_rst_pulse
);
    bus_dec_t          dec;
    logic [WORD_W-1:0] cause_q, mask_q, code_q, word_mux;
    logic [WORD_W-1:0] fifo_q [NUM_FIFO_REGS];
    logic [NUM_FIFO_REGS-1:0] fifo_wr;

    // address decode; odd byte addresses map to nothing
    always_comb begin
        dec.sel     = bus_addr[0] ? SEL_NONE
                                  : decode_index(32'(bus_addr[ADDR_W-1:2]));
        dec.wr_word = bus_sel & bus_wr & ~bus_half;
        dec.rd_any  = bus_sel & ~bus_wr;
        dec.rd_half = bus_half;
        dec.lo_half = bus_addr[1];
    end

    sysif_cause_reg #(.NSRC(NSRC)) u_cause (
        .clk         (clk),
        .rst         (rst),
        .w1c_en      (dec.wr_word && dec.sel == SEL_CAUSE),
        .w1c_data    (bus_wdata),
        .src_set     (src_set),
        .src_clr     (src_clr),
        .btn_pressed (btn_pressed),
        .cause_q     (cause_q)
    );

    always_ff @(posedge clk) begin
        if (rst)                                     mask_q <= '0;
        else if (dec.wr_word && dec.sel == SEL_MASK) mask_q <= bus_wdata;
    end

    for (genvar g = 0; g < NUM_FIFO_REGS; g++) begin : g_fifo
        assign fifo_wr[g] = dec.wr_word && (dec.sel == fifo_sel(g));
        sysif_fifo_addr #(.ALIGN(ALIGN_BITS)) u_ptr (
            .clk   (clk),
            .rst   (rst),
            .wr_en (fifo_wr[g]),
            .wdata (bus_wdata),
            .ptr_q (fifo_q[g])
        );
    end

    sysif_reset_code u_rcode (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (dec.wr_word && dec.sel == SEL_RCODE),
        .wdata       (bus_wdata),
        .legacy_mode (legacy_mode),
        .code_q      (code_q),
        .drv_pulse   (drv_rst_pulse)
    );

    always_comb begin
        case (dec.sel)
            SEL_CAUSE: word_mux = cause_q;
            SEL_MASK:  word_mux = mask_q;
            SEL_FBASE: word_mux = fifo_q[0];
            SEL_FEND:  word_mux = fifo_q[1];
            SEL_FWPTR: word_mux = fifo_q[2];
            SEL_RCODE: word_mux = code_q;
            SEL_REV:   word_mux = REV_ID;
            default:   word_mux = '0;
        endcase
        if (!dec.rd_any)     bus_rdata = '0;
        else if (dec.rd_half) bus_rdata = half_pick(word_mux, dec.lo_half);
        else                 bus_rdata = word_mux;
    end

    assign irq_out = |(cause_q & mask_q);

    // R3: full-word mask load
    a_r3_mask_load: assert property (@(posedge clk) disable iff (rst)
        (dec.wr_word && dec.sel == SEL_MASK) |=> (mask_q == $past(bus_wdata)));

    // R11: halfword writes leave the mask untouched
    a_r11_half_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_half) |=> $stable(mask_q));

    // R1: with nothing enabled there is no interrupt
    a_r1_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq_out);

endmodule

// File: tb/sysif_irq_regs_tb.sv
module sysif_irq_regs_tb_top;
    import sysif_pkg::*;

    localparam int unsigned AW = 12;
    localparam int unsigned NV = 32;
    // row layout: {op[1:0], addr[11:0], data[31:0], expect[31:0]}
    // op 0 = word write, 1 = half write, 2 = word read, 3 = half read
    localparam logic [77:0] VEC [NV] = '{
        {2'd2, 12'h000, 32'h0, 32'h0001_0100},  // R6
        {2'd2, 12'h004, 32'h0, 32'h0},          // R6
        {2'd2, 12'h00C, 32'h0, 32'h0},          // R6
        {2'd2, 12'h024, 32'h0, 32'h0},          // R6
        {2'd0, 12'h004, 32'h1234_5678, 32'h0},  // R3
        {2'd2, 12'h004, 32'h0, 32'h1234_5678},  // R3
        {2'd3, 12'h004, 32'h0, 32'h0000_1234},  // R10
        {2'd3, 12'h006, 32'h0, 32'h0000_5678},  // R10
        {2'd1, 12'h004, 32'h0, 32'h0},          // R11
        {2'd2, 12'h004, 32'h0, 32'h1234_5678},  // R11
        {2'd0, 12'h00C, 32'hDEAD_BEEF, 32'h0},  // R7
        {2'd2, 12'h00C, 32'h0, 32'hDEAD_BEE0},  // R7
        {2'd0, 12'h010, 32'h0000_003F, 32'h0},  // R7
        {2'd2, 12'h010, 32'h0, 32'h0000_0020},  // R7
        {2'd0, 12'h014, 32'h0000_001F, 32'h0},  // R7
        {2'd2, 12'h014, 32'h0, 32'h0},          // R7
        {2'd2, 12'h02C, 32'h0, 32'h2465_00B1},  // R8
        {2'd0, 12'h02C, 32'h0, 32'h0},          // R8
        {2'd2, 12'h02C, 32'h0, 32'h2465_00B1},  // R8
        {2'd3, 12'h02C, 32'h0, 32'h0000_2465},  // R10
        {2'd3, 12'h02E, 32'h0, 32'h0000_00B1},  // R10
        {2'd0, 12'h024, 32'h0000_0004, 32'h0},  // R9
        {2'd2, 12'h024, 32'h0, 32'h0000_0004},  // R9
        {2'd2, 12'h008, 32'h0, 32'h0},          // R12
        {2'd0, 12'h018, 32'hFFFF_FFFF, 32'h0},  // R12
        {2'd2, 12'h018, 32'h0, 32'h0},          // R12
        {2'd2, 12'h001, 32'h0, 32'h0},          // R12
        {2'd0, 12'h000, 32'h0000_0100, 32'h0},  // R2
        {2'd2, 12'h000, 32'h0, 32'h0001_0000},  // R2
        {2'd0, 12'h000, 32'h0, 32'h0},          // R2
        {2'd2, 12'h000, 32'h0, 32'h0001_0000},  // R2
        {2'd0, 12'h004, 32'h0, 32'h0}           // R3
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_sel = 1'b0, bus_wr = 1'b0, bus_half = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NUM_SRC-1:0] src_set = '0, src_clr = '0;
    logic              btn_pressed = 1'b0, legacy_mode = 1'b0;
    logic              irq_out, drv_rst_pulse;

    int unsigned total = 0, bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    sysif_irq_regs #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_half(bus_half), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .src_set(src_set), .src_clr(src_clr),
        .btn_pressed(btn_pressed), .legacy_mode(legacy_mode),
        .irq_out(irq_out), .drv_rst_pulse(drv_rst_pulse)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    // all tasks start and end on a falling edge
    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d, input logic h);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_half = h; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_half = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic h, output logic [31:0] v);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_half = h; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0; bus_half = 1'b0;
    endtask

    task automatic pulse_src(input logic [NUM_SRC-1:0] s, input logic [NUM_SRC-1:0] c);
        src_set = s; src_clr = c;
        @(negedge clk);
        src_set = '0; src_clr = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R6 irq_out after reset", {31'b0, irq_out}, 32'd0);
        check("R6 drv_rst_pulse after reset", {31'b0, drv_rst_pulse}, 32'd0);

        for (int i = 0; i < int'(NV); i++) begin
            logic [1:0]    op;
            logic [AW-1:0] a;
            logic [31:0]   d, e;
            {op, a, d, e} = VEC[i];
            case (op)
                2'd0: do_write(a, d, 1'b0);
                2'd1: do_write(a, d, 1'b1);
                default: begin
                    do_read(a, op[0], v);
                    check($sformatf("vector %0d", i), v, e);
                end
            endcase
        end

        // R4 / R1: a peripheral request is latched, the mask gates the line
        pulse_src(15'h0008, '0);
        do_read(12'h000, 1'b0, v);
        check("R4 set request latched", v, 32'h0001_0008);
        check("R1 masked cause gives no irq", {31'b0, irq_out}, 32'd0);
        do_write(12'h004, 32'h0000_0008, 1'b0);
        check("R1 enabled cause raises irq", {31'b0, irq_out}, 32'd1);
        do_write(12'h000, 32'h0000_0008, 1'b0);
        check("R1 irq drops after clear", {31'b0, irq_out}, 32'd0);

        // R4: set and clear in the same cycle, set wins
        pulse_src(15'h0010, 15'h0010);
        do_read(12'h000, 1'b0, v);
        check("R4 set beats clear", v, 32'h0001_0010);
        pulse_src('0, 15'h0010);
        do_read(12'h000, 1'b0, v);
        check("R4 clear request", v, 32'h0001_0000);

        // R4: set and software clear together, set wins
        src_set = 15'h0020;
        do_write(12'h000, 32'h0000_0020, 1'b0);
        src_set = '0;
        do_read(12'h000, 1'b0, v);
        check("R4 set beats software clear", v, 32'h0001_0020);
        do_write(12'h000, 32'h0000_0020, 1'b0);

        // R5: button bit tracks the inverse of the button
        do_write(12'h004, 32'h0001_0000, 1'b0);
        check("R5 released button raises irq", {31'b0, irq_out}, 32'd1);
        btn_pressed = 1'b1;
        @(negedge clk);
        @(negedge clk);
        do_read(12'h000, 1'b0, v);
        check("R5 pressed clears bit 16", v, 32'h0000_0000);
        check("R5 pressed gives no irq", {31'b0, irq_out}, 32'd0);
        btn_pressed = 1'b0;
        @(negedge clk);
        @(negedge clk);
        do_read(12'h000, 1'b0, v);
        check("R5 release sets bit 16", v, 32'h0001_0000);
        do_write(12'h000, 32'h0001_0000, 1'b0);
        do_read(12'h000, 1'b0, v);
        check("R5 software clears button bit", v, 32'h0);
        check("R1 irq low after button clear", {31'b0, irq_out}, 32'd0);

        // R9: drive reset pulse and its blocking conditions
        legacy_mode = 1'b1;
        do_write(12'h024, 32'h0000_0000, 1'b0);
        check("R9 pulse after qualifying write", {31'b0, drv_rst_pulse}, 32'd1);
        @(negedge clk);
        check("R9 pulse lasts one cycle", {31'b0, drv_rst_pulse}, 32'd0);
        do_write(12'h024, 32'h0000_0004, 1'b0);
        check("R9 no pulse with bit 2 set", {31'b0, drv_rst_pulse}, 32'd0);
        legacy_mode = 1'b0;
        do_write(12'h024, 32'h0000_0000, 1'b0);
        check("R9 no pulse outside legacy mode", {31'b0, drv_rst_pulse}, 32'd0);
        do_write(12'h024, 32'h0000_0004, 1'b0);
        legacy_mode = 1'b1;
        do_write(12'h024, 32'h0000_0000, 1'b1);
        check("R11 no pulse on half write", {31'b0, drv_rst_pulse}, 32'd0);
        do_read(12'h024, 1'b0, v);
        check("R11 half write leaves reset code", v, 32'h0000_0004);

        // R12: fifo reset slot write leaves fifo registers alone
        do_write(12'h018, 32'h0000_0000, 1'b0);
        do_read(12'h00C, 1'b0, v);
        check("R12 fifo reset write has no effect", v, 32'hDEAD_BEE0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule